// File: doc/BRIEF.md
# Two-Stage ALU Scan Engine

This block folds a stream of signed 32-bit integers through two chained binary ALU stages. Both stages take a running cache value as their second operand. The first stage combines the incoming element with the cache. The second stage combines that intermediate result with the same cache value. The second stage's result then becomes the new cache. One recurrence therefore gives a plain reduction, a running (cumulative) value, or a prefix scan, depending only on which results are sent out.

A row is a run of elements ending with an element that carries the last flag. At the start of every row the cache is seeded with either zero or a supplied initial value. In reduce mode the only output is the folded value after the last element. In cumulative and scan modes every element produces an output. A configuration checker rejects unsupported settings by raising an error flag and closing the input stream.

Both streams use a valid/ready handshake and move one element per cycle. Configuration is expected to stay stable for the whole length of a row.

Top module: `scan_alu_engine`

## Requirements
- R1: Stage 0 computes op0(x, c) from element x and cache c. When swap0 is 1 it computes op0(c, x) instead.
- R2: Stage 1 computes op1(t, c) from the stage-0 result t and the same cache c. When swap1 is 1 it computes op1(c, t) instead.
- R3: After each accepted element the cache takes the stage-1 result. The cache is seeded again on the first element after an element carrying in_last, so rows do not affect each other.
- R4: With cfg_mode 1 (cumulative) or 2 (scan), each accepted element produces an output on the next cycle, carrying the stage-1 result. Its out_last equals that element's in_last.
- R5: With cfg_mode 0 (reduce), elements without in_last produce no output. The element with in_last produces a single output holding the final cache value, with out_last set to 1.
- R6: cfg_init code 3 seeds the cache with 0. Code 5 seeds it with cfg_init_value.
- R7: The opcodes are 0 pass (returns the first operand), 4 add, 5 subtract (first minus second), 6 multiply, 8 max, 9 min, 13 and, 14 or, 15 xor, and the signed compares 18 eq, 19 ne, 20 gt, 21 ge, 22 lt and 23 le. A compare returns 1 when true and 0 when false. Arithmetic wraps modulo 2^32.
- R8: cfg_error is 1, and in_ready is held at 0, in any of these cases: an opcode outside the R7 set, cfg_mode 3, an init code other than 3 or 5, or init code 5 with cfg_init_valid at 0. Input offered while cfg_error is 1 produces no output and leaves the row not yet started.
- R9: While out_valid is 1 and out_ready is 0, out_data and out_last hold steady and in_ready is 0. When out_ready returns to 1, the held output and a new input can be exchanged in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_op0 | input | 5 | Stage-0 opcode |
| cfg_op1 | input | 5 | Stage-1 opcode |
| cfg_swap0 | input | 1 | Swap stage-0 operand order |
| cfg_swap1 | input | 1 | Swap stage-1 operand order |
| cfg_mode | input | 2 | 0 reduce, 1 cumulative, 2 scan |
| cfg_init | input | 3 | Cache seed code: 3 zero, 5 load |
| cfg_init_valid | input | 1 | Initial value is supplied |
| cfg_init_value | input | 32 | Initial cache value for code 5 |
| cfg_error | output | 1 | Configuration rejected |
| in_valid | input | 1 | Input element valid |
| in_ready | output | 1 | Engine accepts an element |
| in_data | input | 32 | Input element, signed |
| in_last | input | 1 | Element ends the row |
| out_valid | output | 1 | Output value valid |
| out_ready | input | 1 | Consumer accepts output |
| out_data | output | 32 | Running or final value |
| out_last | output | 1 | Output belongs to the row's last element |

## Verification
A cache that goes wrong shows up in the very next output in cumulative and scan modes, because every element exposes the running value one cycle after it is accepted. In reduce mode the same fault stays hidden until the last element of the row, so the bench runs the same data in both modes. A missed re-seed at a row boundary appears as a carry-over in the first output of the following row, and identical back-to-back rows expose that. A wrong row-start flag or a lost hold under backpressure shows up at once as a shifted value or a changed out_data during a stall.

// File: rtl/scan_alu_pkg.sv
// Shared encodings for the two-stage ALU scan engine.
// Assumes opcodes fit in 5 bits and init codes in 3 bits.
package scan_alu_pkg;

    localparam int OP_W   = 5;
    localparam int MODE_W = 2;
    localparam int INIT_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_PASS = 5'd0,
        OP_ADD  = 5'd4,
        OP_SUB  = 5'd5,
        OP_MUL  = 5'd6,
        OP_MAX  = 5'd8,
        OP_MIN  = 5'd9,
        OP_AND  = 5'd13,
        OP_OR   = 5'd14,
        OP_XOR  = 5'd15,
        OP_EQ   = 5'd18,
        OP_NE   = 5'd19,
        OP_GT   = 5'd20,
        OP_GE   = 5'd21,
        OP_LT   = 5'd22,
        OP_LE   = 5'd23
    } alu_op_e;

    typedef enum logic [MODE_W-1:0] {
        RUN_REDUCE = 2'd0,
        RUN_CUMUL  = 2'd1,
        RUN_SCAN   = 2'd2
    } run_mode_e;

    localparam logic [INIT_W-1:0] SEED_ZERO = 3'd3;
    localparam logic [INIT_W-1:0] SEED_LOAD = 3'd5;

    // True when the opcode belongs to the supported set.
    function automatic logic op_known(input logic [OP_W-1:0] op);
        case (op)
            5'd0, 5'd4, 5'd5, 5'd6, 5'd8, 5'd9,
            5'd13, 5'd14, 5'd15,
            5'd18, 5'd19, 5'd20, 5'd21, 5'd22, 5'd23: op_known = 1'b1;
            default:                                  op_known = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/scan_alu_stage.sv
// One combinational ALU stage: applies an opcode to (element, cache), or to
// (cache, element) when swap is set. Signed data, wrapping arithmetic.
// Assumes the opcode was already validated; unknown codes pass operand a.
module scan_alu_stage
    import scan_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [OP_W-1:0]   op,
    input  logic              swap,
    input  logic [DATA_W-1:0] elem,
    input  logic [DATA_W-1:0] cache,
    output logic [DATA_W-1:0] result
);
    localparam logic [DATA_W-1:0] ONE  = {{(DATA_W-1){1'b0}}, 1'b1};
    localparam logic [DATA_W-1:0] ZERO = '0;

    logic signed [DATA_W-1:0] opa;
    logic signed [DATA_W-1:0] opb;

    // Operand order selection.
    always_comb begin
        opa = swap ? cache : elem;
        opb = swap ? elem  : cache;
    end

    // Opcode evaluation.
    always_comb begin
        case (alu_op_e'(op))
            OP_PASS: result = opa;
            OP_ADD:  result = opa + opb;
            OP_SUB:  result = opa - opb;
            OP_MUL:  result = opa * opb;
            OP_MAX:  result = (opa > opb) ? opa : opb;
            OP_MIN:  result = (opa < opb) ? opa : opb;
            OP_AND:  result = opa & opb;
            OP_OR:   result = opa | opb;
            OP_XOR:  result = opa ^ opb;
            OP_EQ:   result = (opa == opb) ? ONE : ZERO;
            OP_NE:   result = (opa != opb) ? ONE : ZERO;
            OP_GT:   result = (opa >  opb) ? ONE : ZERO;
            OP_GE:   result = (opa >= opb) ? ONE : ZERO;
            OP_LT:   result = (opa <  opb) ? ONE : ZERO;
            OP_LE:   result = (opa <= opb) ? ONE : ZERO;
            default: result = opa;
        endcase
    end

endmodule

// File: rtl/scan_cfg_check.sv
// Configuration validator. Flags unsupported opcodes, the unused mode code,
// unknown seed codes and a load seed without a supplied value.
// Assumes configuration is static during a row.
module scan_cfg_check
    import scan_alu_pkg::*;
#(
    parameter int N_STAGE = 2
) (
    input  logic [N_STAGE-1:0][OP_W-1:0] ops,
    input  logic [MODE_W-1:0]            mode,
    input  logic [INIT_W-1:0]            seed,
    input  logic                         seed_present,
    output logic                         bad
);
    logic [N_STAGE-1:0] op_bad;

    // Per-stage opcode membership test.
    for (genvar g = 0; g < N_STAGE; g++) begin : g_opchk
        assign op_bad[g] = !op_known(ops[g]);
    end

    // Combine all rejection causes.
    always_comb begin
        bad = |op_bad;
        if (mode == 2'd3)                               bad = 1'b1;
        if (seed != SEED_ZERO && seed != SEED_LOAD)     bad = 1'b1;
        if (seed == SEED_LOAD && !seed_present)         bad = 1'b1;
    end

endmodule

// File: rtl/scan_alu_engine.sv
// Two-stage ALU scan engine. Each accepted element runs through two chained
// stages that share the running cache as operand; the cache takes the final
// stage result. Mode selects reduce (final only) or per-element output.
// Assumes configuration is stable from a row's first element to its last.
module scan_alu_engine
    import scan_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        cfg_op0,
    input  logic [4:0]        cfg_op1,
    input  logic              cfg_swap0,
    input  logic              cfg_swap1,
    input  logic [1:0]        cfg_mode,
    input  logic [2:0]        cfg_init,
    input  logic              cfg_init_valid,
    input  logic [DATA_W-1:0] cfg_init_value,
    output logic              cfg_error,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last
);
    localparam int N_STAGE = 2;

    logic [N_STAGE-1:0][OP_W-1:0] st_op;
    logic [N_STAGE-1:0]           st_swap;
    logic [DATA_W-1:0]            chain [N_STAGE+1];

    logic [DATA_W-1:0] cache_q;
    logic [DATA_W-1:0] cache_use;
    logic              row_start_q;
    logic              out_valid_q;
    logic [DATA_W-1:0] out_data_q;
    logic              out_last_q;
    logic              accept;
    logic              emit;

    assign st_op   = {cfg_op1, cfg_op0};
    assign st_swap = {cfg_swap1, cfg_swap0};

    scan_cfg_check #(.N_STAGE(N_STAGE)) u_cfg (
        .ops          (st_op),
        .mode         (cfg_mode),
        .seed         (cfg_init),
        .seed_present (cfg_init_valid),
        .bad          (cfg_error)
    );

    // Cache operand: seed at row start, running value otherwise.
    always_comb begin
        if (row_start_q)
            cache_use = (cfg_init == SEED_LOAD) ? cfg_init_value : '0;
        else
            cache_use = cache_q;
    end

    assign chain[0] = in_data;

    for (genvar g = 0; g < N_STAGE; g++) begin : g_stage
        scan_alu_stage #(.DATA_W(DATA_W)) u_stage (
            .op     (st_op[g]),
            .swap   (st_swap[g]),
            .elem   (chain[g]),
            .cache  (cache_use),
            .result (chain[g+1])
        );
    end

    // Handshake and output-emit decisions.
    always_comb begin
        in_ready = !cfg_error && (!out_valid_q || out_ready);
        accept   = in_valid && in_ready;
        emit     = accept && ((run_mode_e'(cfg_mode) != RUN_REDUCE) || in_last);
    end

    // Cache and row-boundary tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cache_q     <= '0;
            row_start_q <= 1'b1;
        end else if (accept) begin
            cache_q     <= chain[N_STAGE];
            row_start_q <= in_last;
        end
    end

    // Output register with hold under backpressure.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_q <= 1'b0;
            out_data_q  <= '0;
            out_last_q  <= 1'b0;
        end else if (emit) begin
            out_valid_q <= 1'b1;
            out_data_q  <= chain[N_STAGE];
            out_last_q  <= in_last;
        end else if (out_ready) begin
            out_valid_q <= 1'b0;
        end
    end

    assign out_valid = out_valid_q;
    assign out_data  = out_data_q;
    assign out_last  = out_last_q;

endmodule

// File: rtl/scan_alu_engine_chk.sv
// Port-level protocol checker for the scan engine, bound to the top module.
// Assumes configuration is stable while outputs of a row are pending.
module scan_alu_engine_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        cfg_mode,
    input logic              cfg_error,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_last,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              out_last
);
    AST_ERR_CLOSES_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_error |-> !in_ready); // R8

    AST_ERR_NO_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_error && !out_valid) |=> !out_valid); // R8

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R9

    AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready); // R9

    AST_REDUCE_ONLY_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cfg_mode == 2'd0) |-> out_last); // R5

    AST_EVERY_ELEM_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && cfg_mode != 2'd0) |=> (out_valid && out_last == $past(in_last))); // R4

endmodule

bind scan_alu_engine scan_alu_engine_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/scan_alu_engine_tb.sv
`timescale 1ns/1ps
// Self-checking bench: table-driven rows, then directed reset, error and
// backpressure cases.
module scan_alu_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  cfg_op0 = 5'd4, cfg_op1 = 5'd0;
    logic        cfg_swap0 = 1'b0, cfg_swap1 = 1'b0;
    logic [1:0]  cfg_mode = 2'd2;
    logic [2:0]  cfg_init = 3'd3;
    logic        cfg_init_valid = 1'b0;
    logic [31:0] cfg_init_value = '0;
    logic        cfg_error;
    logic        in_valid = 1'b0, in_ready, in_last = 1'b0;
    logic [31:0] in_data = '0;
    logic        out_valid, out_ready = 1'b1, out_last;
    logic [31:0] out_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    scan_alu_engine dut_i (.*);

    typedef struct packed {
        logic [4:0]       op0;
        logic [4:0]       op1;
        logic             sw0;
        logic             sw1;
        logic [1:0]       mode;
        logic [2:0]       init;
        logic [31:0]      ival;
        logic [3:0][31:0] din;
        logic [3:0][31:0] dout;
    } vec_t;

    // din/dout listed first-element-first; reduce rows only use the final slot.
    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{5'd4,  5'd0, 1'b0, 1'b0, 2'd2, 3'd3, 32'd0,
          '{32'd1, 32'd2, 32'd3, 32'd4}, '{32'd1, 32'd3, 32'd6, 32'd10}},
        '{5'd4,  5'd0, 1'b0, 1'b0, 2'd0, 3'd3, 32'd0,
          '{32'd1, 32'd2, 32'd3, 32'd4}, '{32'd0, 32'd0, 32'd0, 32'd10}},
        '{5'd8,  5'd0, 1'b0, 1'b0, 2'd1, 3'd5, -32'sd100,
          '{32'd5, -32'sd3, 32'd7, 32'd2}, '{32'd5, 32'd5, 32'd7, 32'd7}},
        '{5'd5,  5'd0, 1'b1, 1'b0, 2'd2, 3'd5, 32'd100,
          '{32'd10, 32'd20, 32'd30, 32'd5}, '{32'd90, 32'd70, 32'd40, 32'd35}},
        '{5'd5,  5'd0, 1'b0, 1'b0, 2'd2, 3'd3, 32'd0,
          '{32'd10, 32'd3, 32'd8, 32'd1}, '{32'd10, -32'sd7, 32'd15, -32'sd14}},
        '{5'd0,  5'd6, 1'b0, 1'b1, 2'd2, 3'd5, 32'd1,
          '{32'd2, 32'd3, 32'd4, 32'd5}, '{32'd2, 32'd6, 32'd24, 32'd120}},
        '{5'd20, 5'd0, 1'b0, 1'b0, 2'd2, 3'd5, 32'd0,
          '{32'd3, 32'd0, 32'd5, 32'd1}, '{32'd1, 32'd0, 32'd1, 32'd0}},
        '{5'd15, 5'd13, 1'b0, 1'b0, 2'd2, 3'd5, 32'hFF,
          '{32'h0F, 32'h30, 32'hFF, 32'h01}, '{32'hF0, 32'hC0, 32'h00, 32'h00}},
        '{5'd4,  5'd0, 1'b0, 1'b0, 2'd0, 3'd5, 32'h7FFFFFFF,
          '{32'd1, 32'd0, 32'd0, 32'd0}, '{32'd0, 32'd0, 32'd0, 32'h80000000}},
        '{5'd14, 5'd0, 1'b0, 1'b0, 2'd1, 3'd3, 32'd0,
          '{32'd4, 32'd1, 32'd8, 32'd2}, '{32'd4, 32'd5, 32'd13, 32'd15}}
    };

    // Compare one value and report on mismatch.
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [4:0] o0, input logic [4:0] o1, input logic s0,
                           input logic s1, input logic [1:0] m, input logic [2:0] ini,
                           input logic [31:0] iv);
        cfg_op0 = o0; cfg_op1 = o1; cfg_swap0 = s0; cfg_swap1 = s1;
        cfg_mode = m; cfg_init = ini; cfg_init_valid = (ini == 3'd5); cfg_init_value = iv;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        check("R9 reset out_valid", {31'd0, out_valid}, 32'd0);
        check("R8 reset in_ready", {31'd0, in_ready}, 32'd1);

        // Table rows, R1 R2 R3 R4 R5 R6 R7
        for (int v = 0; v < NV; v++) begin
            set_cfg(VECS[v].op0, VECS[v].op1, VECS[v].sw0, VECS[v].sw1,
                    VECS[v].mode, VECS[v].init, VECS[v].ival);
            for (int k = 3; k >= 0; k--) begin
                in_valid = 1'b1;
                in_data  = VECS[v].din[k];
                in_last  = (k == 0);
                @(negedge clk);
                if (VECS[v].mode != 2'd0 || k == 0) begin
                    check("R4 out_valid", {31'd0, out_valid}, 32'd1);
                    check("R3 out_data", out_data, VECS[v].dout[k]);
                    check("R4 out_last", {31'd0, out_last}, {31'd0, k == 0});
                end else begin
                    check("R5 reduce suppressed", {31'd0, out_valid}, 32'd0);
                end
            end
            in_valid = 1'b0; in_last = 1'b0;
            @(negedge clk);
        end

        // R8 load seed without a value
        set_cfg(5'd4, 5'd0, 1'b0, 1'b0, 2'd2, 3'd5, 32'd7);
        cfg_init_valid = 1'b0;
        #1;
        check("R8 missing seed error", {31'd0, cfg_error}, 32'd1);
        check("R8 in_ready closed", {31'd0, in_ready}, 32'd0);
        in_valid = 1'b1; in_data = 32'd50; in_last = 1'b1;
        @(negedge clk);
        check("R8 no output on error", {31'd0, out_valid}, 32'd0);
        cfg_init_valid = 1'b1; in_data = 32'd3;
        @(negedge clk);
        check("R8 row unaffected", out_data, 32'd10);
        in_valid = 1'b0; in_last = 1'b0;
        @(negedge clk);

        // R8 other rejection causes
        set_cfg(5'd2, 5'd0, 1'b0, 1'b0, 2'd2, 3'd3, 32'd0); #1;
        check("R8 bad op0", {31'd0, cfg_error}, 32'd1);
        set_cfg(5'd4, 5'd24, 1'b0, 1'b0, 2'd2, 3'd3, 32'd0); #1;
        check("R8 bad op1", {31'd0, cfg_error}, 32'd1);
        set_cfg(5'd4, 5'd0, 1'b0, 1'b0, 2'd3, 3'd3, 32'd0); #1;
        check("R8 bad mode", {31'd0, cfg_error}, 32'd1);
        set_cfg(5'd4, 5'd0, 1'b0, 1'b0, 2'd2, 3'd4, 32'd0); #1;
        check("R8 bad seed code", {31'd0, cfg_error}, 32'd1);
        set_cfg(5'd23, 5'd0, 1'b0, 1'b0, 2'd2, 3'd3, 32'd0); #1;
        check("R7 le accepted", {31'd0, cfg_error}, 32'd0);
        @(negedge clk);

        // R9 backpressure
        set_cfg(5'd4, 5'd0, 1'b0, 1'b0, 2'd2, 3'd3, 32'd0);
        out_ready = 1'b0;
        in_valid = 1'b1; in_data = 32'd5; in_last = 1'b0;
        @(negedge clk);
        in_data = 32'd6; in_last = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R9 held valid", {31'd0, out_valid}, 32'd1);
        check("R9 held data", out_data, 32'd5);
        check("R9 in_ready low", {31'd0, in_ready}, 32'd0);
        out_ready = 1'b1;
        @(negedge clk);
        check("R9 next data", out_data, 32'd11);
        check("R9 next last", {31'd0, out_last}, 32'd1);
        in_valid = 1'b0; in_last = 1'b0;
        @(negedge clk);

        // R5 R6 single-element reduce row with loaded seed
        set_cfg(5'd4, 5'd0, 1'b0, 1'b0, 2'd0, 3'd5, 32'd9);
        in_valid = 1'b1; in_data = -32'sd4; in_last = 1'b1;
        @(negedge clk);
        check("R5 single final", out_data, 32'd5);
        check("R5 single last", {31'd0, out_last}, 32'd1);
        in_valid = 1'b0; in_last = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule